// File: doc/BRIEF.md
# Signed Tally Sweep Engine

This block walks a fixed-length run of signed elements held in a single-port synchronous memory. It reads the elements one at a time, in address order. Each element moves a signed tally: the tally goes up by one when the element is strictly positive, and down by one when it is zero or negative. After each update the block stores the new tally back into the element it just read. When every element has been visited, the block raises a completion flag and presents the final tally.

A host sets the base address and pulses start. The engine latches the base and clears its tally and its index. For each element it then steps through five controller states:

- a loop check;
- a read;
- an evaluation that branches on the element's sign;
- one of two separate update states (increment or decrement);
- a write-back.

Only one element is in flight at a time.

Top module: `tally_sweep`

## Requirements
- R1: After reset the block is idle: `done` is 0, `mem_rd` and `mem_wr` are 0, and `result` reads 0.
- R2: A start pulse in the idle or done state latches `base_addr` and clears the tally and the index. A start pulse while a sweep is running is ignored: it changes neither the written values nor the sweep length.
- R3: Reads go to addresses base, base+1, ..., base+COUNT-1 in that order, each exactly once. Each read is followed by exactly one write to the same address. No other address is written.
- R4: Treating the element as a DATA_W-bit two's complement value, an element greater than zero adds 1 to the tally, and an element equal to zero or negative subtracts 1. The tally always stays within -COUNT..+COUNT.
- R5: The value written for an element is the tally after that element's update, sign-extended to DATA_W bits.
- R6: `mem_rd` and `mem_wr` are never high in the same cycle.
- R7: `done` rises exactly 5*COUNT+1 cycles after the clock edge that accepts start. It stays high, with `result` equal to the final tally (signed, CNT_W bits), until the next start.
- R8: The sign branch uses two distinct controller states. Every write therefore comes exactly three cycles after its read, whichever branch was taken.
- R9: A start from the done state drops `done` and runs a fresh sweep, whose tally does not depend on the previous result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (honoured only when idle or done) |
| base_addr | input | ADDR_W | Address of the first element |
| mem_rd | output | 1 | Memory read strobe; data returns the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory address for read or write |
| mem_wdata | output | DATA_W | Tally value to store |
| mem_rdata | input | DATA_W | Memory read data, one cycle after `mem_rd` |
| done | output | 1 | Sweep finished; held until next start |
| result | output | CNT_W | Final signed tally |

## Verification
The bench builds the engine with COUNT=20, DATA_W=8 and ADDR_W=6, so the array sits inside a 64-word memory model. This makes it practical to check every written word and every untouched word after each sweep. The short sweep lets many element patterns run, each from a different base:

- all positive, all zero and all negative;
- alternating signs;
- the extremes 127 and -128;
- a pseudo-random mix.

Together these drive the tally to both of its bounds and through zero. Restarts from the done state and start pulses during a sweep are also covered. Each run keeps the 5*COUNT+1 latency small enough to count exactly.

// File: rtl/tally_pkg.sv
package tally_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_EVAL, ST_UP, ST_DOWN, ST_WRITE, ST_DONE
  } tally_state_e;

  // tally must span -n..+n: magnitude bits plus a sign bit
  function automatic int unsigned ctr_width(input int unsigned n);
    return $clog2(n + 1) + 1;
  endfunction

  // signed test; caller passes the element sign-extended
  function automatic logic elem_positive(input logic signed [63:0] v);
    return v > 64'sd0;
  endfunction

endpackage

// File: rtl/tally_ctrl.sv
module tally_ctrl
  import tally_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic more,
  input  logic positive,
  output logic clr,
  output logic rd_en,
  output logic up,
  output logic down,
  output logic wr_en,
  output logic done
);

  tally_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    clr     = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: if (start) begin
        clr     = 1'b1;
        state_d = ST_CHECK;
      end
      ST_CHECK: state_d = more ? ST_READ : ST_DONE;
      ST_READ:  state_d = ST_EVAL;
      ST_EVAL:  state_d = positive ? ST_UP : ST_DOWN;
      ST_UP:    state_d = ST_WRITE;
      ST_DOWN:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_CHECK;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign rd_en = (state_q == ST_READ);
  assign up    = (state_q == ST_UP);
  assign down  = (state_q == ST_DOWN);
  assign wr_en = (state_q == ST_WRITE);
  assign done  = (state_q == ST_DONE);

  // R8: evaluation always leads to exactly one update state
  assert_branch_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL) |=> (up || down));

  // R2: a start seen mid-sweep does not clear
  assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && state_q != ST_IDLE && start) |-> !clr);

endmodule

// File: rtl/tally_data.sv
module tally_data #(
  parameter int unsigned COUNT  = 100,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     up,
  input  logic                     down,
  input  logic                     adv,
  input  logic [ADDR_W-1:0]        base_addr,
  output logic                     more,
  output logic [ADDR_W-1:0]        addr,
  output logic signed [CNT_W-1:0]  count,
  output logic [DATA_W-1:0]        wdata
);

  localparam int unsigned IDX_W = $clog2(COUNT + 1);
  localparam logic signed [CNT_W-1:0] CMAX = CNT_W'(COUNT);
  localparam logic signed [CNT_W-1:0] CMIN = -CMAX;

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      base_q <= '0;
      count  <= '0;
    end else if (clr) begin
      idx_q  <= '0;
      base_q <= base_addr;
      count  <= '0;
    end else begin
      if (up)   count <= count + CNT_W'(1);
      if (down) count <= count - CNT_W'(1);
      if (adv)  idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign more  = (idx_q < IDX_W'(COUNT));
  assign addr  = base_q + ADDR_W'(idx_q);
  assign wdata = DATA_W'(count);

  assert_tally_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= CMIN) && (count <= CMAX));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    up |=> (count == $past(count) + CNT_W'(1)));

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    down |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/tally_sweep.sv
module tally_sweep
  import tally_pkg::*;
#(
  parameter int unsigned COUNT  = 100,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = ctr_width(COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic [CNT_W-1:0]  result
);

  // named internal events
  logic clr_ev, up_ev, down_ev, more_w, positive_w;
  logic signed [CNT_W-1:0] count_w;

  assign positive_w = elem_positive(64'($signed(mem_rdata)));

  tally_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .more(more_w),
    .positive(positive_w), .clr(clr_ev), .rd_en(mem_rd),
    .up(up_ev), .down(down_ev), .wr_en(mem_wr), .done(done)
  );

  tally_data #(.COUNT(COUNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rst_n(rst_n), .clr(clr_ev), .up(up_ev), .down(down_ev),
    .adv(mem_wr), .base_addr(base_addr), .more(more_w), .addr(mem_addr),
    .count(count_w), .wdata(mem_wdata)
  );

  assign result = count_w;

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_wr_follows_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd, 3) && (mem_addr == $past(mem_addr, 3))));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && result == '0));

endmodule

// File: tb/tb_tally_sweep.sv
module tb_tally_sweep;

  localparam int N  = 20;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int RW = $clog2(N + 1) + 1;
  localparam int MEMSZ = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic mem_rd, mem_wr, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [RW-1:0] result;

  logic [DW-1:0] mem [MEMSZ];
  logic [DW-1:0] expm [MEMSZ];

  int total = 0, bad = 0;
  int rd_count = 0, rd_base = 0, last_rd_addr = -1, last_rd_cyc = 0, cyc = 0;
  bit monitor_on = 0;

  always #2.5 clk = ~clk;

  tally_sweep #(.COUNT(N), .DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .result(result)
  );

  always_ff @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (monitor_on) begin
      if (mem_rd && mem_wr) check(0, "R6 rd/wr overlap", 1, 0);
      if (mem_rd) begin
        check(int'(mem_addr) == ((rd_base + rd_count) % MEMSZ), "R3 read order",
              int'(mem_addr), (rd_base + rd_count) % MEMSZ);
        rd_count++;
        last_rd_addr = int'(mem_addr);
        last_rd_cyc  = cyc;
      end
      if (mem_wr) begin
        check(int'(mem_addr) == last_rd_addr, "R3 write address", int'(mem_addr), last_rd_addr);
        check(cyc - last_rd_cyc == 3, "R8 read-to-write gap", cyc - last_rd_cyc, 3);
      end
    end
  end

  function automatic logic [DW-1:0] pattern(input int p, input int k, inout logic [15:0] lf);
    case (p)
      0: return 8'd5;
      1: return 8'd0;
      2: return 8'hFD;
      3: return (k % 2 == 0) ? 8'd1 : 8'hFF;
      4: begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[7:0];
      end
      default: case (k % 5)
        0: return 8'd127; 1: return 8'h80; 2: return 8'd0; 3: return 8'd1; default: return 8'hFF;
      endcase
    endcase
  endfunction

  task automatic run(input int p, input int base, input bit glitch);
    logic [15:0] lf = 16'hACE1 + 16'(base);
    int x = 0;
    int n = 0;
    for (int a = 0; a < MEMSZ; a++) begin mem[a] = 8'hA5; expm[a] = 8'hA5; end
    for (int k = 0; k < N; k++) begin
      logic [DW-1:0] e = pattern(p, k, lf);
      mem[(base + k) % MEMSZ] = e;
      if ($signed(e) > 0) x++; else x--;   // R4
      expm[(base + k) % MEMSZ] = DW'(x);    // R5
    end
    @(negedge clk);
    rd_count = 0; rd_base = base; last_rd_addr = -1;
    base_addr = AW'(base); start = 1;
    @(negedge clk);
    start = 0;
    base_addr = AW'(base + 7);
    while (!done && n < 5 * N + 50) begin
      start = (glitch && n == 7) ? 1'b1 : 1'b0;  // R2 ignored mid-sweep
      @(negedge clk);
      n++;
    end
    start = 0;
    check(n == 5 * N + 1, "R7 latency", n, 5 * N + 1);
    check($signed(result) == x, "R4 final tally", $signed(result), x);
    check(rd_count == N, "R3 read count", rd_count, N);
    for (int a = 0; a < MEMSZ; a++)
      check(mem[a] == expm[a], "R5/R3 memory word", int'(mem[a]), int'(expm[a]));
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R7 done held", done, 1);
    check($signed(result) == x, "R7 result held", $signed(result), x);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 0, "R1 done at reset", done, 0);
    check(mem_rd == 0 && mem_wr == 0, "R1 strobes at reset", mem_rd + mem_wr, 0);
    rst_n = 1;
    @(negedge clk);
    check(done == 0, "R1 done idle", done, 0);
    check(result == 0, "R1 result idle", int'(result), 0);
    monitor_on = 1;
    run(0, 0, 0);    // all positive: reaches +N
    run(1, 44, 0);   // all zero: reaches -N (R4 zero decrements)
    run(2, 10, 0);   // all negative
    run(3, 3, 0);    // alternating signs
    run(4, 30, 0);   // pseudo-random mix
    run(5, 17, 0);   // extremes 127, -128
    run(3, 50, 1);   // R2 start pulse mid-sweep ignored
    run(2, 5, 0);    // R9 restart after a positive-free run
    run(0, 5, 0);    // R9 fresh tally despite earlier result
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule